// File: doc/BRIEF.md
# Microcoded Operand-Select ALU

This block is the arithmetic and logic stage of a bit-sliced datapath. It is handed three register values (an A-port word, a B-port word and the Q word), a direct data word D, a carry-in and a 6-bit micro-op. The low three bits of the micro-op pick which pair of those values, or a forced zero, feeds the R and S operands. The upper three bits pick one of three carry-aware arithmetic operations or one of five logic operations. Increment, decrement, negate, pass, clear and masking all come out of these pairings without extra hardware.

The result F is returned with four status bits: sign, zero, signed overflow and carry-out. The datapath is combinational. By default an output register, cleared by a synchronous active-low reset, holds the result and status for one clock. Setting `REG_OUT` to 0 removes that register.

Top module: `mslice_alu`

## Requirements
- R1: `uop[2:0]` selects the (R, S) pair: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0), where 0 is a forced all-zero operand.
- R2: `uop[5:3]`=0 gives F = R + S + carry_in, modulo 2^32.
- R3: `uop[5:3]`=1 gives F = S + ~R + carry_in. This is S-R-1 with carry_in low and S-R with carry_in high.
- R4: `uop[5:3]`=2 gives F = R + ~S + carry_in, with the same carry convention as R3.
- R5: `uop[5:3]` values 3,4,5,6,7 give R|S, R&S, ~R&S, R^S and ~(R^S) respectively.
- R6: For `uop[5:3]` values 3 to 7, carry_in has no effect on F.
- R7: sign_o equals bit 31 of F.
- R8: zero_o is 1 exactly when all 32 bits of F are 0.
- R9: ovf_o is 1 when an arithmetic result falls outside the signed 32-bit range. It is 0 for every logic function.
- R10: cout_o is the carry out of bit 31 of the arithmetic sum. It is 0 for every logic function.
- R11: The combined cases hold. Source 3 with function 0 and carry_in 1 gives B+1. Source 4 with function 2 and carry_in 1 gives -A. Source 2 with function 1 and carry_in 0 gives Q-1.
- R12: With `REG_OUT`=1, every output shows the result of the inputs present at the previous rising clock edge. A clock edge with rst_n low sets F=0, zero_o=1 and the other status bits to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_port | input | 32 | A-port register value |
| b_port | input | 32 | B-port register value |
| q_reg | input | 32 | Q register value |
| d_in | input | 32 | Direct data word |
| carry_in | input | 1 | Carry into bit 0 for arithmetic functions |
| uop | input | 6 | [2:0] operand pair select, [5:3] function select |
| f_out | output | 32 | ALU result F |
| sign_o | output | 1 | Sign bit of F |
| zero_o | output | 1 | High when F is all zeros |
| ovf_o | output | 1 | Signed overflow of an arithmetic function |
| cout_o | output | 1 | Carry out of bit 31 of an arithmetic function |

## Verification
Under the default build, F and all four status bits are due exactly one rising edge after the operands and micro-op are applied. The bench changes inputs on a falling edge and reads every output on the following falling edge, half a period after the register loads. For each change it also reads the outputs 1 ns after the inputs move, before any rising edge, and expects the previous values, which shows that nothing leaks through combinationally. The reset values are read on the falling edge after a reset edge, while the inputs are held at non-zero values.

// File: rtl/mslice_alu_pkg.sv
// Shared types for the operand-select ALU.
// Assumes the micro-op layout: [2:0] operand pair, [5:3] function.
package mslice_alu_pkg;

    // Operand pair selection; the encoding is decoded directly from uop[2:0].
    typedef enum logic [2:0] {
        SRC_APORT_QREG = 3'd0,
        SRC_APORT_BPORT = 3'd1,
        SRC_NIL_QREG   = 3'd2,
        SRC_NIL_BPORT  = 3'd3,
        SRC_NIL_APORT  = 3'd4,
        SRC_DIN_APORT  = 3'd5,
        SRC_DIN_QREG   = 3'd6,
        SRC_DIN_NIL    = 3'd7
    } src_sel_e;

    // Function selection; codes 0..2 are arithmetic, 3..7 are logic.
    typedef enum logic [2:0] {
        OP_SUM       = 3'd0,
        OP_S_LESS_R  = 3'd1,
        OP_R_LESS_S  = 3'd2,
        OP_IOR       = 3'd3,
        OP_CONJ      = 3'd4,
        OP_CLEAR_BY_R = 3'd5,
        OP_DIFF      = 3'd6,
        OP_MATCH     = 3'd7
    } fn_sel_e;

    // True when the function routes through the adder.
    function automatic logic fn_is_arith(input fn_sel_e fn);
        return (fn == OP_SUM) || (fn == OP_S_LESS_R) || (fn == OP_R_LESS_S);
    endfunction

endpackage

// File: rtl/mslice_operand_mux.sv
// Operand pair selector.
// Builds R from {A-port, D, zero} and S from {A-port, B-port, Q, zero}
// according to the source code. Purely combinational.
module mslice_operand_mux
    import mslice_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    input  logic [W-1:0] q_val,
    input  logic [W-1:0] d_val,
    input  src_sel_e     src,
    output logic [W-1:0] r_op,
    output logic [W-1:0] s_op
);

    // Select the R operand: A-port, direct data or inhibited to zero.
    always_comb begin
        case (src)
            SRC_APORT_QREG, SRC_APORT_BPORT:            r_op = a_val;
            SRC_DIN_APORT, SRC_DIN_QREG, SRC_DIN_NIL:   r_op = d_val;
            default:                                    r_op = '0;
        endcase
    end

    // Select the S operand: A-port, B-port, Q or inhibited to zero.
    always_comb begin
        case (src)
            SRC_APORT_QREG, SRC_NIL_QREG, SRC_DIN_QREG: s_op = q_val;
            SRC_APORT_BPORT, SRC_NIL_BPORT:             s_op = b_val;
            SRC_NIL_APORT, SRC_DIN_APORT:               s_op = a_val;
            default:                                    s_op = '0;
        endcase
    end

endmodule

// File: rtl/mslice_alu_core.sv
// Function unit: one shared adder for the three arithmetic codes and a
// bitwise unit for the five logic codes. Subtraction is done by inverting
// one operand and adding carry_in. The adder is split at the top bit so the
// carry into the MSB is available for overflow detection.
// Assumes W >= 2.
module mslice_alu_core
    import mslice_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] r_op,
    input  logic [W-1:0] s_op,
    input  logic         carry_in,
    input  fn_sel_e      fn,
    output logic [W-1:0] f,
    output logic         arith,
    output logic         c_into_msb,
    output logic         c_from_msb
);

    localparam int MSB = W - 1;

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic [W-1:0] low_sum;
    logic         sum_msb;
    logic [W-1:0] logic_res;

    // Condition the adder inputs: invert R or S for the two subtractions.
    always_comb begin
        case (fn)
            OP_S_LESS_R: begin add_x = ~r_op; add_y = s_op;  end
            OP_R_LESS_S: begin add_x = r_op;  add_y = ~s_op; end
            default:     begin add_x = r_op;  add_y = s_op;  end
        endcase
    end

    // Add the lower bits, then resolve the top bit and its carries.
    always_comb begin
        low_sum    = {1'b0, add_x[MSB-1:0]} + {1'b0, add_y[MSB-1:0]}
                   + {{MSB{1'b0}}, carry_in};
        c_into_msb = low_sum[MSB];
        sum_msb    = add_x[MSB] ^ add_y[MSB] ^ c_into_msb;
        c_from_msb = (add_x[MSB] & add_y[MSB])
                   | (c_into_msb & (add_x[MSB] ^ add_y[MSB]));
    end

    // Bitwise functions; carry_in does not reach this path.
    always_comb begin
        case (fn)
            OP_IOR:        logic_res = r_op | s_op;
            OP_CONJ:       logic_res = r_op & s_op;
            OP_CLEAR_BY_R: logic_res = ~r_op & s_op;
            OP_DIFF:       logic_res = r_op ^ s_op;
            OP_MATCH:      logic_res = ~(r_op ^ s_op);
            default:       logic_res = '0;
        endcase
    end

    assign arith = fn_is_arith(fn);
    assign f     = arith ? {sum_msb, low_sum[MSB-1:0]} : logic_res;

endmodule

// File: rtl/mslice_status.sv
// Status generation from the result and adder carries.
// Overflow is the disagreement of the carries into and out of the MSB.
// Carry-out and overflow are forced low for logic functions.
module mslice_status #(
    parameter int W = 32
) (
    input  logic [W-1:0] f,
    input  logic         arith,
    input  logic         c_into_msb,
    input  logic         c_from_msb,
    output logic         sign,
    output logic         zero,
    output logic         ovf,
    output logic         cout
);

    // Derive the four status bits.
    always_comb begin
        sign = f[W-1];
        zero = ~|f;
        ovf  = arith & (c_into_msb ^ c_from_msb);
        cout = arith & c_from_msb;
    end

endmodule

// File: rtl/mslice_alu.sv
// Top of the operand-select ALU.
// Decodes the micro-op, runs operand selection, the function unit and the
// status logic, then either registers the outputs (REG_OUT=1) or passes
// them straight through (REG_OUT=0). The register uses a synchronous
// active-low reset to F=0 with the zero flag set.
module mslice_alu
    import mslice_alu_pkg::*;
#(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_port,
    input  logic [W-1:0] b_port,
    input  logic [W-1:0] q_reg,
    input  logic [W-1:0] d_in,
    input  logic         carry_in,
    input  logic [5:0]   uop,
    output logic [W-1:0] f_out,
    output logic         sign_o,
    output logic         zero_o,
    output logic         ovf_o,
    output logic         cout_o
);

    src_sel_e     src;
    fn_sel_e      fn;
    logic [W-1:0] r_op;
    logic [W-1:0] s_op;
    logic [W-1:0] f_c;
    logic         arith_c;
    logic         cin_msb_c;
    logic         cout_msb_c;
    logic         sign_c;
    logic         zero_c;
    logic         ovf_c;
    logic         cout_c;

    assign src = src_sel_e'(uop[2:0]);
    assign fn  = fn_sel_e'(uop[5:3]);

    mslice_operand_mux #(.W(W)) opmux_i (
        .a_val (a_port),
        .b_val (b_port),
        .q_val (q_reg),
        .d_val (d_in),
        .src   (src),
        .r_op  (r_op),
        .s_op  (s_op)
    );

    mslice_alu_core #(.W(W)) core_i (
        .r_op       (r_op),
        .s_op       (s_op),
        .carry_in   (carry_in),
        .fn         (fn),
        .f          (f_c),
        .arith      (arith_c),
        .c_into_msb (cin_msb_c),
        .c_from_msb (cout_msb_c)
    );

    mslice_status #(.W(W)) status_i (
        .f          (f_c),
        .arith      (arith_c),
        .c_into_msb (cin_msb_c),
        .c_from_msb (cout_msb_c),
        .sign       (sign_c),
        .zero       (zero_c),
        .ovf        (ovf_c),
        .cout       (cout_c)
    );

    generate
        if (REG_OUT) begin : g_out_reg
            // Hold result and status for one clock; reset to a clean zero result.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    f_out  <= '0;
                    sign_o <= 1'b0;
                    zero_o <= 1'b1;
                    ovf_o  <= 1'b0;
                    cout_o <= 1'b0;
                end else begin
                    f_out  <= f_c;
                    sign_o <= sign_c;
                    zero_o <= zero_c;
                    ovf_o  <= ovf_c;
                    cout_o <= cout_c;
                end
            end
        end else begin : g_out_comb
            // Present the combinational result directly.
            always_comb begin
                f_out  = f_c;
                sign_o = sign_c;
                zero_o = zero_c;
                ovf_o  = ovf_c;
                cout_o = cout_c;
            end
        end
    endgenerate

endmodule

// File: rtl/mslice_alu_chk.sv
// Assertion checker for mslice_alu, attached by bind.
// Keeps a copy of the micro-op aligned with the output timing so that the
// properties relate the outputs to the function that produced them.
module mslice_alu_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [5:0]   uop,
    input logic [W-1:0] f_out,
    input logic         sign_o,
    input logic         zero_o,
    input logic         ovf_o,
    input logic         cout_o
);

    logic [5:0] uop_q;
    logic [5:0] uop_seen;

    // Track the micro-op that the registered outputs belong to.
    always_ff @(posedge clk) begin
        if (!rst_n) uop_q <= 6'd0;
        else        uop_q <= uop;
    end

    assign uop_seen = REG_OUT ? uop_q : uop;

    AST_SIGN_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        sign_o == f_out[W-1]); // R7
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (f_out == '0)); // R8
    AST_LOGIC_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_seen[5:3] >= 3'd3) |-> !ovf_o); // R9
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_seen[5:3] >= 3'd3) |-> !cout_o); // R10
    AST_NIL_PAIR_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((uop_seen[5:3] == 3'd4) && (uop_seen[2:0] inside {3'd2, 3'd3, 3'd4, 3'd7}))
        |-> (f_out == '0)); // R1

endmodule

bind mslice_alu mslice_alu_chk #(.W(W), .REG_OUT(REG_OUT)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .uop    (uop),
    .f_out  (f_out),
    .sign_o (sign_o),
    .zero_o (zero_o),
    .ovf_o  (ovf_o),
    .cout_o (cout_o)
);

// File: tb/mslice_alu_tb_top.sv
`timescale 1ns/1ps
// Bench for mslice_alu with the default registered outputs.
// Inputs change on a falling edge; results are read on the next falling edge.
module mslice_alu_tb_top;

    typedef struct packed {
        logic [31:0] f;
        logic        sgn;
        logic        zr;
        logic        ov;
        logic        co;
    } res_t;

    typedef struct packed {
        logic [5:0]  uop;
        logic        cin;
        logic [31:0] f;
        logic        sgn;
        logic        zr;
        logic        ov;
        logic        co;
    } vec_t;

    // Fixed operands for the table: A=0x10, B=0x7FFFFFFF, Q=3, D=0xFFFFFFF0.
    localparam logic [31:0] TA = 32'h0000_0010;
    localparam logic [31:0] TB = 32'h7FFF_FFFF;
    localparam logic [31:0] TQ = 32'h0000_0003;
    localparam logic [31:0] TD = 32'hFFFF_FFF0;
    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{6'o03, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R11 B+1
        '{6'o24, 1'b1, 32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b0}, // R11 -A
        '{6'o12, 1'b0, 32'h0000_0002, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 Q-1
        '{6'o21, 1'b1, 32'h8000_0011, 1'b1, 1'b0, 1'b0, 1'b0}, // A-B
        '{6'o47, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0}, // D & 0
        '{6'o05, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1}, // D+A wraps
        '{6'o71, 1'b1, 32'h8000_0010, 1'b1, 1'b0, 1'b0, 1'b0}, // ~(A^B)
        '{6'o56, 1'b0, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 1'b0}, // ~D & Q
        '{6'o30, 1'b1, 32'h0000_0013, 1'b0, 1'b0, 1'b0, 1'b0}, // A | Q
        '{6'o66, 1'b0, 32'hFFFF_FFF3, 1'b1, 1'b0, 1'b0, 1'b0}, // D ^ Q
        '{6'o06, 1'b1, 32'hFFFF_FFF4, 1'b1, 1'b0, 1'b0, 1'b0}  // D+Q+1
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] a_port, b_port, q_reg, d_in;
    logic        carry_in;
    logic [5:0]  uop;
    logic [31:0] f_out;
    logic        sign_o, zero_o, ovf_o, cout_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mslice_alu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_port   (a_port),
        .b_port   (b_port),
        .q_reg    (q_reg),
        .d_in     (d_in),
        .carry_in (carry_in),
        .uop      (uop),
        .f_out    (f_out),
        .sign_o   (sign_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o),
        .cout_o   (cout_o)
    );

    // Independent model of the requirements.
    function automatic res_t model(input logic [5:0] op, input logic ci,
                                   input logic [31:0] a, b, q, d);
        logic [31:0] r, s;
        logic [32:0] u;
        longint      t;
        res_t        o;
        case (op[2:0])
            3'd0: begin r = a;  s = q;  end
            3'd1: begin r = a;  s = b;  end
            3'd2: begin r = 0;  s = q;  end
            3'd3: begin r = 0;  s = b;  end
            3'd4: begin r = 0;  s = a;  end
            3'd5: begin r = d;  s = a;  end
            3'd6: begin r = d;  s = q;  end
            default: begin r = d; s = 0; end
        endcase
        u = '0; t = 0;
        case (op[5:3])
            3'd0: begin u = {1'b0, r} + {1'b0, s} + 33'(ci);
                  t = longint'($signed(r)) + longint'($signed(s)) + longint'(ci); end
            3'd1: begin u = {1'b0, s} + {1'b0, ~r} + 33'(ci);
                  t = longint'($signed(s)) - longint'($signed(r)) - 1 + longint'(ci); end
            3'd2: begin u = {1'b0, r} + {1'b0, ~s} + 33'(ci);
                  t = longint'($signed(r)) - longint'($signed(s)) - 1 + longint'(ci); end
            3'd3: u[31:0] = r | s;
            3'd4: u[31:0] = r & s;
            3'd5: u[31:0] = ~r & s;
            3'd6: u[31:0] = r ^ s;
            default: u[31:0] = ~(r ^ s);
        endcase
        o.f   = u[31:0];
        o.sgn = u[31];
        o.zr  = (u[31:0] == 32'd0);
        o.ov  = (op[5:3] <= 3'd2) && (t > 64'sd2147483647 || t < -64'sd2147483648);
        o.co  = (op[5:3] <= 3'd2) && u[32];
        return o;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req_f, input res_t e);
        chk(req_f, "F", f_out, e.f);
        chk("R7", "sign", 32'(sign_o), 32'(e.sgn));
        chk("R8", "zero", 32'(zero_o), 32'(e.zr));
        chk("R9", "ovf", 32'(ovf_o), 32'(e.ov));
        chk("R10", "cout", 32'(cout_o), 32'(e.co));
    endtask

    // Drive on a falling edge, confirm outputs held (R12), read a clock later.
    task automatic apply(input logic [5:0] op, input logic ci,
                         input logic [31:0] a, b, q, d, input string req_f,
                         input res_t e);
        logic [31:0] prev_f;
        @(negedge clk);
        prev_f = f_out;
        uop = op; carry_in = ci; a_port = a; b_port = b; q_reg = q; d_in = d;
        #1;
        chk("R12", "F before edge", f_out, prev_f);
        @(negedge clk);
        chk_all(req_f, e);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        res_t e;
        string tag;
        rst_n = 1'b0;
        a_port = 32'hDEAD_BEEF; b_port = 32'h1234_5678; q_reg = 32'h5; d_in = 32'h9;
        carry_in = 1'b1; uop = 6'o01;
        repeat (3) @(negedge clk);
        // R12 reset state with non-zero inputs present
        chk("R12", "reset F", f_out, 32'd0);
        chk("R12", "reset zero", 32'(zero_o), 32'd1);
        chk("R12", "reset sign/ovf/cout", {29'd0, sign_o, ovf_o, cout_o}, 32'd0);
        rst_n = 1'b1;

        // Table of directed vectors on fixed operands
        for (int i = 0; i < NVEC; i++) begin
            e = '{VECS[i].f, VECS[i].sgn, VECS[i].zr, VECS[i].ov, VECS[i].co};
            apply(VECS[i].uop, VECS[i].cin, TA, TB, TQ, TD,
                  (i < 3) ? "R11" : "R1", e);
        end

        // Negative minus positive overflows: 0x80000000 - 1 (R9, R10)
        e = '{32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b1};
        apply(6'o21, 1'b1, 32'h8000_0000, 32'd1, 32'd0, 32'd0, "R4", e);

        // R6: logic result unchanged by carry_in
        e = model(6'o61, 1'b0, 32'hF0F0_1234, 32'h0FF0_4321, 0, 0);
        apply(6'o61, 1'b1, 32'hF0F0_1234, 32'h0FF0_4321, 0, 0, "R6", e);

        // Full sweep of source/function/carry with random operands
        for (int sf = 0; sf < 64; sf++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [31:0] ra, rb, rq, rd;
                    ra = $urandom; rb = $urandom; rq = $urandom; rd = $urandom;
                    case (sf / 8)
                        0: tag = "R2";
                        1: tag = "R3";
                        2: tag = "R4";
                        default: tag = (ci == 1) ? "R6" : "R5";
                    endcase
                    e = model(6'(sf), 1'(ci), ra, rb, rq, rd);
                    apply(6'(sf), 1'(ci), ra, rb, rq, rd, tag, e);
                end
            end
        end

        // R12: synchronous reset clears a live non-zero result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12", "reset again F", f_out, 32'd0);
        chk("R12", "reset again zero", 32'(zero_o), 32'd1);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule